// File: doc/BRIEF.md
# Serial RGB LED Chain Refresh Controller

This block drives a daisy chain of serial-input RGB LED driver modules through four wires: a data line, a shift clock, a latch strobe and an active-low driver enable. A host fills a colour buffer that holds one red, green and blue entry per module, addressed by module index. The host also sets a shared set of configuration registers: three dot-correction values and a PWM clock mode. Each channel is stored as 10 bits.

A pulse on `start` launches one full refresh. The controller first sends one configuration word per module and strobes the latch. It then sends one colour word per module, buffer entry 0 first. It turns the drivers off, strobes the latch, waits a settle interval and turns the drivers back on. The `eight_bit` input is sampled at start. When it is set, only the low 8 bits of each stored channel are used, and each one is sent as the top of a 10-bit field. Any buffer or configuration write that arrives while a refresh runs is dropped and flagged.

The control state machine has eight states. IDLE waits for `start`. CFG_LOAD hands a configuration word to the bit shifter, and CFG_WAIT waits for the shifter's done pulse. From CFG_WAIT the machine goes back to CFG_LOAD while modules remain, or on to CFG_LATCH after the last one. CFG_LATCH holds the latch high and then goes to COL_LOAD. COL_LOAD and COL_WAIT send the colour words in the same way and lead to OFF_LATCH. OFF_LATCH drives the enable high together with a latch pulse and then goes to SETTLE. SETTLE counts out the settle delay and returns to IDLE, driving the enable low on that transition.

Top module: `led_chain_ctrl`

## Requirements
- R1: Out of reset, led_data, led_clk and led_latch are 0, led_en_n is 1, busy is 0 and wr_err is 0.
- R2: Each word is 32 bits, sent MSB first with one bit per led_clk high pulse. Each high pulse lasts CLK_DIV system cycles, and led_data never changes while led_clk is high.
- R3: A refresh starts with NUM_MOD configuration words and one latch pulse after them. Each configuration word holds: bits 31:30 = 01, bits 29:27 = 0, blue dot correction in 26:20, bits 19:17 = 0, red dot correction in 16:10, bit 9 = 0, clock mode in 8:7 and green dot correction in 6:0.
- R4: After the configuration latch, NUM_MOD colour words follow, buffer entry 0 first. Each colour word holds bits 31:30 = 00, blue in 29:20, red in 19:10 and green in 9:0.
- R5: When eight_bit is 1 at start, each channel field is the stored value's bits 7:0 followed by two 0 bits. When it is 0, the field is the full 10-bit value.
- R6: After the last colour word, led_en_n is 1 when the second latch pulse rises. It then stays 1, with the latch low, for exactly SETTLE_CYC cycles after the latch falls, and then goes to 0.
- R7: busy goes high in the cycle after start is accepted and falls in the same cycle that led_en_n returns to 0. A start pulse during a refresh is ignored.
- R8: A colour or configuration write while busy is 1 leaves the stored values unchanged and raises wr_err in the following cycle.
- R9: Out of reset, the dot-correction and clock-mode registers and all colour entries are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a refresh (ignored while busy) |
| eight_bit | input | 1 | Colour width select, sampled at start (1 = 8-bit) |
| wr_en | input | 1 | Colour buffer write strobe |
| wr_idx | input | IDX_W | Module index of the colour write |
| wr_red | input | 10 | Red value to store |
| wr_grn | input | 10 | Green value to store |
| wr_blu | input | 10 | Blue value to store |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_dc_red | input | 7 | Red dot-correction value |
| cfg_dc_grn | input | 7 | Green dot-correction value |
| cfg_dc_blu | input | 7 | Blue dot-correction value |
| cfg_clk_mode | input | 2 | PWM clock mode value |
| led_data | output | 1 | Serial data to the chain |
| led_clk | output | 1 | Shift clock to the chain |
| led_latch | output | 1 | Latch strobe |
| led_en_n | output | 1 | Driver enable, active low |
| busy | output | 1 | Refresh in progress |
| wr_err | output | 1 | A write was rejected in the previous cycle |

## Verification
Refreshes run first with an untouched buffer, where every configuration word is a bare header and every colour word is zero. They then run with all-ones values and with alternating-bit values such as 0x2A5. These patterns show whether the field positions, the MSB-first order and the 8-bit padding are right, because a misplaced or truncated field changes visible bits. Seeded random contents and random colour widths then catch entry-order and channel-swap faults that fixed patterns can hide. In a directed case, a write and a second start are issued in the middle of a refresh, and the following refresh shows whether the stored values stayed unchanged.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;

    localparam int WORD_W = 32;
    localparam int CH_W   = 10;
    localparam int DC_W   = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG_LOAD,
        ST_CFG_WAIT,
        ST_CFG_LATCH,
        ST_COL_LOAD,
        ST_COL_WAIT,
        ST_OFF_LATCH,
        ST_SETTLE
    } ctl_state_e;

    // channel field as sent: 8-bit mode puts the low byte on top, padded
    function automatic logic [CH_W-1:0] chan_field(input logic [CH_W-1:0] v,
                                                   input logic e8);
        return e8 ? {v[7:0], 2'b00} : v;
    endfunction

    function automatic logic [WORD_W-1:0] build_cfg(input logic [DC_W-1:0] dc_r,
                                                    input logic [DC_W-1:0] dc_g,
                                                    input logic [DC_W-1:0] dc_b,
                                                    input logic [1:0]      mode);
        return {2'b01, 3'b000, dc_b, 3'b000, dc_r, 1'b0, mode, dc_g};
    endfunction

    function automatic logic [WORD_W-1:0] build_col(input logic [CH_W-1:0] r,
                                                    input logic [CH_W-1:0] g,
                                                    input logic [CH_W-1:0] b,
                                                    input logic            e8);
        return {2'b00, chan_field(b, e8), chan_field(r, e8), chan_field(g, e8)};
    endfunction

endpackage

// File: rtl/led_bit_shifter.sv
module led_bit_shifter
    import led_chain_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              sdata,
    output logic              sclk,
    output logic              done
);
    localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BCW = $clog2(WORD_W);

    logic [WORD_W-1:0] shreg;
    logic [BCW-1:0]    bitcnt;
    logic [DCW-1:0]    divcnt;
    logic              active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            divcnt <= '0;
            active <= 1'b0;
            sdata  <= 1'b0;
            sclk   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                shreg  <= word;
                sdata  <= word[WORD_W-1];
                sclk   <= 1'b0;
                bitcnt <= '0;
                divcnt <= '0;
                active <= 1'b1;
            end else if (active) begin
                if (divcnt == DCW'(DIV - 1)) begin
                    divcnt <= '0;
                    if (!sclk) begin
                        sclk <= 1'b1;
                    end else begin
                        sclk <= 1'b0;
                        if (bitcnt == BCW'(WORD_W - 1)) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                            sdata  <= 1'b0;
                        end else begin
                            shreg  <= {shreg[WORD_W-2:0], 1'b0};
                            sdata  <= shreg[WORD_W-2];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end else begin
                    divcnt <= divcnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/led_color_store.sv
module led_color_store
    import led_chain_pkg::*;
#(
    parameter int NUM_MOD = 4,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [CH_W-1:0]  wr,
    input  logic [CH_W-1:0]  wg,
    input  logic [CH_W-1:0]  wb,
    input  logic [IDX_W-1:0] ridx,
    output logic [CH_W-1:0]  rr,
    output logic [CH_W-1:0]  rg,
    output logic [CH_W-1:0]  rb
);
    logic [CH_W-1:0] ent_r [NUM_MOD];
    logic [CH_W-1:0] ent_g [NUM_MOD];
    logic [CH_W-1:0] ent_b [NUM_MOD];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_MOD; i++) begin
                ent_r[i] <= '0;
                ent_g[i] <= '0;
                ent_b[i] <= '0;
            end
        end else if (we) begin
            for (int i = 0; i < NUM_MOD; i++) begin
                if (widx == IDX_W'(i)) begin
                    ent_r[i] <= wr;
                    ent_g[i] <= wg;
                    ent_b[i] <= wb;
                end
            end
        end
    end

    always_comb begin
        rr = '0;
        rg = '0;
        rb = '0;
        for (int i = 0; i < NUM_MOD; i++) begin
            if (ridx == IDX_W'(i)) begin
                rr = ent_r[i];
                rg = ent_g[i];
                rb = ent_b[i];
            end
        end
    end

endmodule

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
    import led_chain_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [DC_W-1:0] dc_r_in,
    input  logic [DC_W-1:0] dc_g_in,
    input  logic [DC_W-1:0] dc_b_in,
    input  logic [1:0]      mode_in,
    output logic [DC_W-1:0] dc_r,
    output logic [DC_W-1:0] dc_g,
    output logic [DC_W-1:0] dc_b,
    output logic [1:0]      mode
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_r <= '0;
            dc_g <= '0;
            dc_b <= '0;
            mode <= '0;
        end else if (we) begin
            dc_r <= dc_r_in;
            dc_g <= dc_g_in;
            dc_b <= dc_b_in;
            mode <= mode_in;
        end
    end
endmodule

// File: rtl/led_chain_ctrl.sv
module led_chain_ctrl
    import led_chain_pkg::*;
#(
    parameter int NUM_MOD    = 4,
    parameter int CLK_DIV    = 2,
    parameter int SETTLE_CYC = 20,
    localparam int IDX_W     = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             eight_bit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [9:0]       wr_red,
    input  logic [9:0]       wr_grn,
    input  logic [9:0]       wr_blu,
    input  logic             cfg_we,
    input  logic [6:0]       cfg_dc_red,
    input  logic [6:0]       cfg_dc_grn,
    input  logic [6:0]       cfg_dc_blu,
    input  logic [1:0]       cfg_clk_mode,
    output logic             led_data,
    output logic             led_clk,
    output logic             led_latch,
    output logic             led_en_n,
    output logic             busy,
    output logic             wr_err
);
    localparam int CNT_MAX = (CLK_DIV > SETTLE_CYC) ? CLK_DIV : SETTLE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    ctl_state_e        state, state_nx;
    logic [IDX_W-1:0]  widx;
    logic [CNT_W-1:0]  cnt;
    logic              mode8;
    logic              sh_done;
    logic              sh_load;
    logic [WORD_W-1:0] sh_word;
    logic              last_word;
    logic [CH_W-1:0]   rd_r, rd_g, rd_b;
    logic [DC_W-1:0]   dc_r, dc_g, dc_b;
    logic [1:0]        clk_mode;

    led_color_store #(.NUM_MOD(NUM_MOD), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && !busy), .widx(wr_idx),
        .wr(wr_red), .wg(wr_grn), .wb(wr_blu),
        .ridx(widx), .rr(rd_r), .rg(rd_g), .rb(rd_b)
    );

    led_cfg_regs cfg_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we && !busy),
        .dc_r_in(cfg_dc_red), .dc_g_in(cfg_dc_grn), .dc_b_in(cfg_dc_blu),
        .mode_in(cfg_clk_mode),
        .dc_r(dc_r), .dc_g(dc_g), .dc_b(dc_b), .mode(clk_mode)
    );

    assign sh_load   = (state == ST_CFG_LOAD) || (state == ST_COL_LOAD);
    assign sh_word   = (state == ST_CFG_LOAD) ? build_cfg(dc_r, dc_g, dc_b, clk_mode)
                                              : build_col(rd_r, rd_g, rd_b, mode8);
    assign last_word = (widx == IDX_W'(NUM_MOD - 1));

    led_bit_shifter #(.DIV(CLK_DIV)) shift_i (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .word(sh_word),
        .sdata(led_data), .sclk(led_clk), .done(sh_done)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start) state_nx = ST_CFG_LOAD;
            ST_CFG_LOAD:  state_nx = ST_CFG_WAIT;
            ST_CFG_WAIT:  if (sh_done) state_nx = last_word ? ST_CFG_LATCH : ST_CFG_LOAD;
            ST_CFG_LATCH: if (cnt == CNT_W'(CLK_DIV - 1)) state_nx = ST_COL_LOAD;
            ST_COL_LOAD:  state_nx = ST_COL_WAIT;
            ST_COL_WAIT:  if (sh_done) state_nx = last_word ? ST_OFF_LATCH : ST_COL_LOAD;
            ST_OFF_LATCH: if (cnt == CNT_W'(CLK_DIV - 1)) state_nx = ST_SETTLE;
            ST_SETTLE:    if (cnt == CNT_W'(SETTLE_CYC - 1)) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // state register with its index and dwell counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            widx  <= '0;
            cnt   <= '0;
            mode8 <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= (state_nx != state) ? '0 : cnt + 1'b1;
            if (state == ST_IDLE && start) begin
                widx  <= '0;
                mode8 <= eight_bit;
            end else if ((state == ST_CFG_WAIT || state == ST_COL_WAIT) && sh_done) begin
                widx <= last_word ? '0 : widx + 1'b1;
            end
        end
    end

    // registered outputs keyed on the upcoming state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_latch <= 1'b0;
            led_en_n  <= 1'b1;
            busy      <= 1'b0;
            wr_err    <= 1'b0;
        end else begin
            led_latch <= (state_nx == ST_CFG_LATCH) || (state_nx == ST_OFF_LATCH);
            if (state_nx == ST_OFF_LATCH)
                led_en_n <= 1'b1;
            else if (state == ST_SETTLE && state_nx == ST_IDLE)
                led_en_n <= 1'b0;
            busy   <= (state_nx != ST_IDLE);
            wr_err <= (wr_en || cfg_we) && busy;
        end
    end

endmodule

// File: rtl/led_chain_chk.sv
module led_chain_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic wr_en,
    input logic cfg_we,
    input logic led_data,
    input logic led_clk,
    input logic led_latch,
    input logic led_en_n,
    input logic busy,
    input logic wr_err
);
    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (led_clk && $past(led_clk)) |-> $stable(led_data));

    // R2
    latch_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        led_latch |-> !led_clk);

    // R7
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!led_latch && !led_clk));

    // R6
    enable_off_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(led_en_n) |-> busy);

    // R8
    write_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || cfg_we) && busy) |=> wr_err);

    // R8
    write_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !wr_err);
endmodule

bind led_chain_ctrl led_chain_chk chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .cfg_we(cfg_we),
    .led_data(led_data), .led_clk(led_clk), .led_latch(led_latch),
    .led_en_n(led_en_n), .busy(busy), .wr_err(wr_err)
);

// File: tb/led_chain_ctrl_tb_top.sv
module led_chain_ctrl_tb_top;
    localparam int N      = 3;
    localparam int DIV    = 2;
    localparam int SETTLE = 6;
    localparam int IW     = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, eight_bit = 0, wr_en = 0, cfg_we = 0;
    logic [IW-1:0] wr_idx = '0;
    logic [9:0] wr_red = '0, wr_grn = '0, wr_blu = '0;
    logic [6:0] cfg_dc_red = '0, cfg_dc_grn = '0, cfg_dc_blu = '0;
    logic [1:0] cfg_clk_mode = '0;
    logic led_data, led_clk, led_latch, led_en_n, busy, wr_err;

    always #2 clk = ~clk;

    led_chain_ctrl #(.NUM_MOD(N), .CLK_DIV(DIV), .SETTLE_CYC(SETTLE)) dut_i (.*);

    int checks = 0, fails = 0, cyc = 0;
    logic [9:0] mr [N], mg [N], mb [N];
    logic [6:0] m_dcr = 0, m_dcg = 0, m_dcb = 0;
    logic [1:0] m_mode = 0;

    logic [31:0] cap [64];
    logic [31:0] shacc = 0;
    int ncap = 0, nb = 0, nlat = 0, settle_run = 0, hi_run = 0;
    int lat_words [8];
    logic lat_en [8];
    logic prev_clk = 0, prev_data = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] fld(input logic [9:0] v, input bit e8);
        return e8 ? {v[7:0], 2'b00} : v;
    endfunction

    function automatic logic [31:0] exp_cfg();
        return {2'b01, 3'b000, m_dcb, 3'b000, m_dcr, 1'b0, m_mode, m_dcg};
    endfunction

    function automatic logic [31:0] exp_col(input int i, input bit e8);
        return {2'b00, fld(mb[i], e8), fld(mr[i], e8), fld(mg[i], e8)};
    endfunction

    // serial capture at the chain's clock
    always @(posedge led_clk) begin
        shacc = {shacc[30:0], led_data};
        nb++;
        if (nb == 32) begin
            if (ncap < 64) cap[ncap] = shacc;
            ncap++;
            nb = 0;
        end
    end

    always @(posedge led_latch) begin
        if (nlat < 8) begin
            lat_words[nlat] = ncap;
            lat_en[nlat]    = led_en_n;
        end
        nlat++;
    end

    // mid-cycle monitors
    always @(negedge clk) begin
        if (rst_n) begin
            if (led_clk && prev_clk && led_data != prev_data)
                chk(0, "R2", "data moved while clock high", 32'(led_data), 32'(prev_data));
            if (led_clk) hi_run++;
            else if (hi_run != 0) begin
                chk(hi_run == DIV, "R2", "clock high width", hi_run, DIV);
                hi_run = 0;
            end
            if (nlat == 2 && !led_latch && led_en_n) settle_run++;
        end
        prev_clk  = led_clk;
        prev_data = led_data;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    task automatic write_col(input int i, input logic [9:0] r, g, b);
        @(negedge clk);
        wr_en = 1; wr_idx = IW'(i); wr_red = r; wr_grn = g; wr_blu = b;
        @(negedge clk);
        wr_en = 0;
        mr[i] = r; mg[i] = g; mb[i] = b;
    endtask

    task automatic write_cfg(input logic [6:0] r, g, b, input logic [1:0] m);
        @(negedge clk);
        cfg_we = 1; cfg_dc_red = r; cfg_dc_grn = g; cfg_dc_blu = b; cfg_clk_mode = m;
        @(negedge clk);
        cfg_we = 0;
        m_dcr = r; m_dcg = g; m_dcb = b; m_mode = m;
    endtask

    task automatic begin_refresh(input bit e8);
        ncap = 0; nb = 0; nlat = 0; settle_run = 0;
        @(negedge clk);
        eight_bit = e8; start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1, "R7", "busy after start", 32'(busy), 1);
    endtask

    task automatic end_refresh(input bit e8);
        while (busy) @(negedge clk);
        chk(led_en_n == 1'b0, "R6", "enable back on", 32'(led_en_n), 0);
        chk(settle_run == SETTLE, "R6", "settle cycles", settle_run, SETTLE);
        chk(nlat == 2, "R7", "latch count", nlat, 2);
        chk(lat_words[0] == N, "R3", "words before config latch", lat_words[0], N);
        chk(lat_words[1] == 2 * N, "R4", "words before colour latch", lat_words[1], 2 * N);
        chk(lat_en[1] == 1'b1, "R6", "drivers off at colour latch", 32'(lat_en[1]), 1);
        chk(nb == 0, "R2", "whole words only", nb, 0);
        for (int i = 0; i < N; i++)
            chk(cap[i] == exp_cfg(), "R3", "config word", cap[i], exp_cfg());
        for (int i = 0; i < N; i++)
            chk(cap[N + i] == exp_col(i, e8), e8 ? "R5" : "R4", "colour word",
                cap[N + i], exp_col(i, e8));
    endtask

    task automatic refresh(input bit e8);
        begin_refresh(e8);
        end_refresh(e8);
    endtask

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < N; i++) begin mr[i] = 0; mg[i] = 0; mb[i] = 0; end
        repeat (3) @(negedge clk);
        chk(led_data == 0 && led_clk == 0 && led_latch == 0, "R1", "lines low in reset",
            {led_data, led_clk, led_latch}, 0);
        chk(led_en_n == 1 && busy == 0 && wr_err == 0, "R1", "enable off, idle",
            {led_en_n, busy, wr_err}, 3'b100);
        rst_n = 1;
        @(negedge clk);

        // R9: untouched registers give bare headers and zero colours
        refresh(0);

        // directed: all ones, then alternating bits in both widths
        write_cfg(7'h7F, 7'h7F, 7'h7F, 2'b11);
        for (int i = 0; i < N; i++) write_col(i, 10'h3FF, 10'h3FF, 10'h3FF);
        refresh(0);
        write_cfg(7'h55, 7'h2A, 7'h33, 2'b01);
        for (int i = 0; i < N; i++) write_col(i, 10'h2A5, 10'h15A, 10'h0F0 + 10'(i));
        refresh(0);
        refresh(1);

        // seeded random contents and widths
        for (int k = 0; k < 5; k++) begin
            write_cfg(7'($urandom), 7'($urandom), 7'($urandom), 2'($urandom));
            for (int i = 0; i < N; i++)
                write_col(i, 10'($urandom), 10'($urandom), 10'($urandom));
            refresh(1'($urandom));
        end

        // R8 / R7: writes and a second start during a refresh
        begin_refresh(0);
        repeat (10) @(negedge clk);
        wr_en = 1; wr_idx = 0; wr_red = ~mr[0]; wr_grn = ~mg[0]; wr_blu = ~mb[0];
        cfg_we = 1; cfg_dc_red = ~m_dcr; cfg_dc_grn = ~m_dcg; cfg_dc_blu = ~m_dcb;
        cfg_clk_mode = ~m_mode;
        @(negedge clk);
        wr_en = 0; cfg_we = 0;
        chk(wr_err == 1'b1, "R8", "write error flag", 32'(wr_err), 1);
        start = 1;
        @(negedge clk);
        start = 0;
        end_refresh(0);
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R7", "start during run ignored", 32'(busy), 0);
        refresh(0);   // R8: stored values unchanged
        write_col(1, 10'h001, 10'h200, 10'h155);
        chk(wr_err == 1'b0, "R8", "no flag for idle write", 32'(wr_err), 0);
        refresh(1);

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule